// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects eight external interrupt request lines and forwards them, one at a time, to a processor over a single interrupt output. A rising edge on a line is remembered in a pending register. A per-line mask can block any line. Of the lines that are pending and not masked, the lowest-numbered one wins. It is forwarded only if it outranks every request the processor is currently servicing.

When the processor acknowledges, the block presents a vector number. It then moves the winning request from pending to in-service. The interrupt service routine retires its request by writing the end-of-interrupt command byte to the command address of the block's 8-bit register port. Until then, requests of equal or lower rank stay held back. A higher-ranked request can still interrupt the service routine. The mask register is written and read through the same port, and the pending and in-service registers can be read there too. The processor's own global interrupt enable is outside this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request is latched into the pending register on a rising edge of its input line; a line held high does not latch again until it has gone low and risen once more.
- R2: The mask register is written at address 0x21 and resets to 0xFF; a set bit stops its line from reaching the interrupt output, and a masked request stays pending and is forwarded once its bit is cleared.
- R3: Priority is fixed, with line 0 highest and line 7 lowest; the request forwarded is the lowest-numbered line that is pending, unmasked and outranks the in-service level.
- R4: While the interrupt output is high, the vector output holds 8 plus the winning line number (lines 0 to 7 give 8 to 15); while it is low the vector output is 0.
- R5: An acknowledge pulse sampled while the interrupt output is high clears the winner's pending bit and sets its in-service bit on the same clock edge.
- R6: While a line is in service, no pending line of equal or lower priority raises the interrupt output; a pending line of higher priority still does.
- R7: A write of data 0x20 to address 0x20 is the end-of-interrupt command and clears the highest-priority in-service bit; a write of any other data to address 0x20 changes nothing.
- R8: An edge on a line that is already in service is latched as pending and is forwarded after the end-of-interrupt command retires that line.
- R9: An end-of-interrupt command received with nothing in service has no effect.
- R10: Reads are combinational from the read address: 0x20 returns the pending register, 0x21 the mask, 0x22 the in-service register, and any other address returns 0.
- R11: An acknowledge pulse while the interrupt output is low changes neither the pending nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Interrupt request inputs, bit 0 highest priority |
| cpu_int | output | 1 | Interrupt output to the processor |
| cpu_ack | input | 1 | One-cycle acknowledge pulse from the processor |
| vector | output | 8 | Vector number of the forwarded request |
| bus_addr | input | 8 | Register port address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |

## Verification
The bench uses the default parameters: eight lines, vector base 8, command address 0x20, mask address 0x21 and in-service read address 0x22. With these values every vector from 8 to 15 can occur. The full 0x00 to 0xFF mask space is reachable. Nesting can reach all eight in-service levels, so the random phase can stack several service routines and then unwind them in order. Directed steps cover a re-edge on a line in service, the wrong command byte, an end-of-interrupt with nothing in service and an acknowledge with no request.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N         = 8,
  parameter int DW        = 8,
  parameter int VEC_BASE  = 8,
  parameter logic [7:0] CMD_ADDR  = 8'h20,
  parameter logic [7:0] MASK_ADDR = 8'h21,
  parameter logic [7:0] SVC_ADDR  = 8'h22,
  parameter logic [7:0] EOI_CODE  = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_lines,
  output logic          cpu_int,
  input  logic          cpu_ack,
  output logic [DW-1:0] vector,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int IW = $clog2(N);

  logic [N-1:0] line_q, pend, mask, svc;
  logic [N-1:0] cand, rise, take, retire;
  logic [IW-1:0] win;
  logic [IW:0]   svc_lvl;
  logic          eoi_hit;

  assign rise    = irq_lines & ~line_q;
  assign cand    = pend & ~mask;
  assign eoi_hit = bus_wr && bus_addr == CMD_ADDR && bus_wdata == EOI_CODE;
  assign retire  = eoi_hit ? (svc & (~svc + N'(1))) : '0;

  always_comb begin
    win     = '0;
    svc_lvl = (IW+1)'(N);
    for (int i = N-1; i >= 0; i--) begin
      if (cand[i]) win = IW'(i);
      if (svc[i])  svc_lvl = (IW+1)'(i);
    end
  end

  assign cpu_int = (|cand) && ({1'b0, win} < svc_lvl);
  assign vector  = cpu_int ? DW'(VEC_BASE) + DW'(win) : '0;
  assign take    = (cpu_ack && cpu_int) ? (N'(1) << win) : '0;

  always_comb begin
    case (bus_addr)
      CMD_ADDR:  bus_rdata = DW'(pend);
      MASK_ADDR: bus_rdata = DW'(mask);
      SVC_ADDR:  bus_rdata = DW'(svc);
      default:   bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      pend   <= '0;
      mask   <= '1;
      svc    <= '0;
    end else begin
      line_q <= irq_lines;
      pend   <= (pend & ~take) | rise;
      svc    <= (svc & ~retire) | take;
      if (bus_wr && bus_addr == MASK_ADDR) mask <= N'(bus_wdata);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_edge_latched_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lines[g] && !line_q[g]) |=> pend[g]);
  end

  p_mask_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mask == '1);

  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> (vector >= DW'(VEC_BASE) && vector < DW'(VEC_BASE + N)));

  p_ack_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_int && !eoi_hit) |=> $countones(svc) == $past($countones(svc)) + 1);

  p_top_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    svc[0] |-> !cpu_int);

  p_idle_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && svc == '0 && !cpu_ack) |=> svc == '0);

  p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_int && !eoi_hit) |=> $stable(svc));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq_lines = 0, vector, bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic cpu_int, cpu_ack = 0, bus_wr = 0;
  int errors = 0, checks = 0;
  logic [7:0] m_pend = 0, m_mask = 8'hFF, m_svc = 0, m_prev = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (.clk, .rst_n, .irq_lines, .cpu_int, .cpu_ack, .vector,
                     .bus_addr, .bus_wr, .bus_wdata, .bus_rdata);

  function automatic int first_set(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int();
    int w = first_set(m_pend & ~m_mask);
    return w < 8 && w < first_set(m_svc);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h20: return m_pend;
      8'h21: return m_mask;
      8'h22: return m_svc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tg, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  task automatic step(input string tg, input logic [7:0] irq, input logic ack,
                      input logic wr, input logic [7:0] a, input logic [7:0] d);
    logic ei; int w, s;
    logic [7:0] take = 0, ret = 0;
    irq_lines = irq; cpu_ack = ack; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    ei = exp_int();
    w  = first_set(m_pend & ~m_mask);
    chk(tg, {7'd0, cpu_int}, {7'd0, ei}, "cpu_int");
    chk(tg, vector, ei ? 8'(8 + w) : 8'h00, "vector");
    chk(tg, bus_rdata, exp_rd(a), "rdata");
    if (ack && ei) take = 8'(1 << w);
    s = first_set(m_svc);
    if (wr && a == 8'h20 && d == 8'h20 && s < 8) ret = 8'(1 << s);
    @(posedge clk);
    m_pend = (m_pend & ~take) | (irq & ~m_prev);
    m_svc  = (m_svc & ~ret) | take;
    if (wr && a == 8'h21) m_mask = d;
    m_prev = irq;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4601));
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R2", 0, 0, 0, 8'h21, 0);
    step("R10", 0, 0, 0, 8'h22, 0);
    step("R10", 0, 0, 0, 8'h5A, 0);
    step("R2", 8'h01, 0, 0, 8'h20, 0);
    step("R2", 8'h01, 0, 1, 8'h21, 8'h00);
    step("R2", 8'h00, 0, 1, 8'h21, 8'h00);
    step("R4", 8'h00, 1, 0, 8'h22, 0);
    step("R7", 8'h00, 0, 1, 8'h20, 8'h20);
    step("R1", 8'h24, 0, 0, 8'h20, 0);
    step("R1", 8'h24, 0, 0, 8'h20, 0);
    step("R3", 8'h24, 0, 0, 8'h20, 0);
    step("R4", 8'h24, 1, 0, 8'h20, 0);
    step("R5", 8'h24, 0, 0, 8'h20, 0);
    step("R5", 8'h24, 0, 0, 8'h22, 0);
    step("R6", 8'h26, 0, 0, 8'h20, 0);
    step("R6", 8'h26, 0, 0, 8'h20, 0);
    step("R4", 8'h26, 1, 0, 8'h22, 0);
    step("R8", 8'h22, 0, 0, 8'h20, 0);
    step("R8", 8'h26, 0, 0, 8'h20, 0);
    step("R7", 8'h26, 0, 1, 8'h20, 8'h21);
    step("R7", 8'h26, 0, 0, 8'h22, 0);
    step("R7", 8'h26, 0, 1, 8'h20, 8'h20);
    step("R8", 8'h26, 0, 1, 8'h20, 8'h20);
    step("R8", 8'h26, 0, 0, 8'h22, 0);
    step("R2", 8'h26, 0, 1, 8'h21, 8'h04);
    step("R2", 8'h26, 0, 0, 8'h20, 0);
    step("R11", 8'h26, 0, 1, 8'h21, 8'hFF);
    step("R11", 8'h26, 1, 0, 8'h20, 0);
    step("R11", 8'h26, 0, 0, 8'h22, 0);
    step("R9", 8'h00, 0, 1, 8'h20, 8'h20);
    step("R9", 8'h00, 0, 1, 8'h20, 8'h20);
    step("R9", 8'h00, 0, 0, 8'h22, 0);
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] irq = irq_lines ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
      logic wr = ($urandom % 6) == 0;
      logic [7:0] a = 8'h20 + 8'($urandom % 4);
      logic [7:0] d = ($urandom % 3 != 0) ? 8'h20 : 8'($urandom) & 8'($urandom);
      step("R3", irq, ($urandom % 4) == 0, wr, a, d);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule